// File: doc/BRIEF.md
# Frame-Gated Event Link Reader

This block moves trigger-object event frames out of an output FIFO and onto the transmit side of a serial transceiver. Each FIFO entry is 33 bits wide: a 32-bit payload and a flag that marks the payload as a control character. A frame is a header, zero or more object words and a trailer. The block takes frames one at a time and only as whole units. An external register counts the complete frames waiting in the FIFO. The block starts a frame only when that count is above zero and the downstream receiver reports that it is ready.

Once a frame has started, the block reads it through to its trailer with no stop, whatever the ready input does. It forwards each word through one registered stage. The same registered strobe that marks a word as valid also writes that word into a spy memory. When the trailer has gone out, the block raises a single-cycle request that tells the frame-count register to decrement. A software reset pulse sends the controller back to idle and abandons any frame in progress. An 8-bit monitor output shows the current state.

The FIFO is read in first-word-fall-through fashion. The head word and its valid flag are already present on the read port, and a read-enable pulse removes that word from the FIFO.

Top module: `frame_link_reader`

## Requirements
- R1: During and after reset, the outputs are as follows: `state_mon` = 0x01, `fifo_rd_en` = 0, `cnt_dec` = 0, `tx_valid` = 0, `tx_is_k` = 1 and `tx_word` = 0x000000BC, which is the idle word.
- R2: If a word is removed at a clock edge (`fifo_rd_en` and `fifo_valid` both high), it is driven in the next cycle. `tx_word` carries bits 31:0 of the word, `tx_is_k` carries bit 32, and `tx_valid` is 1.
- R3: No frame starts while `pend_cnt` is zero, even when ready is high and the FIFO holds words.
- R4: No frame starts while `rx_ready` is 0, even when `pend_cnt` is nonzero.
- R5: A started frame is read in full and not beyond its end, even if `rx_ready` drops part way through. The trailer is a word with bit 32 set and bits 7:0 equal to 0x9C. The first word sent after any frame boundary is the next frame's header.
- R6: `cnt_dec` is high for exactly one cycle per frame. That cycle is the one in which the trailer is on `tx_word`.
- R7: A `sw_rst` pulse puts `state_mon` at 0x01 and holds `tx_valid` low in the next cycle. No read is issued in the cycle of the pulse.
- R8: `fifo_rd_en` is never high while `fifo_empty` is high, and never high while idle (`state_mon` = 0x01).
- R9: `state_mon` reads 0x02 while a frame is streaming and 0x04 during the cycle in which `cnt_dec` is high.
- R10: In any cycle with no forwarded word, including an empty-FIFO gap inside a frame, the outputs carry the idle word 0x000000BC with `tx_is_k` = 1 and `tx_valid` = 0.
- R11: After each frame, `state_mon` returns to 0x01 for at least one cycle. This gives the frame count time to settle before the next start decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software reset pulse, returns the controller to idle |
| rx_ready | input | 1 | Downstream receiver can accept a frame |
| pend_cnt | input | 12 | Complete frames waiting in the FIFO |
| fifo_data | input | 33 | FIFO head word; bit 32 is the control-character flag |
| fifo_valid | input | 1 | FIFO head word is valid |
| fifo_empty | input | 1 | FIFO holds no words |
| fifo_rd_en | output | 1 | Removes the head word from the FIFO |
| cnt_dec | output | 1 | One-cycle request to decrement the frame count |
| tx_word | output | 32 | Transmit payload |
| tx_is_k | output | 1 | Transmit payload is a control character |
| tx_valid | output | 1 | Transmit word is frame data; spy memory write strobe |
| state_mon | output | 8 | Controller state monitor |

## Verification
A controller that misses a trailer shows up at the ports in the next cycle. It keeps reading, so the next frame's header goes out with no idle gap and with no `cnt_dec` pulse beside the trailer. A controller that leaves idle too early shows up within one cycle as a 0x02 on `state_mon` although the previous cycle had a zero count or low ready. A read at an empty FIFO is visible at once on `fifo_rd_en`. A stale or misrouted output stage shows up on the first word: it does not match the word removed one edge earlier, or an idle cycle carries `tx_valid` high.

// File: rtl/flr_pkg.sv
package flr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_DONE   = 2'd2
  } flr_state_e;

  localparam int MON_W = 8;

  function automatic logic [MON_W-1:0] mon_code(input flr_state_e s);
    case (s)
      ST_IDLE:   mon_code = 8'h01;
      ST_STREAM: mon_code = 8'h02;
      ST_DONE:   mon_code = 8'h04;
      default:   mon_code = 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/flr_trailer_det.sv
module flr_trailer_det #(
  parameter int          CODE_W   = 8,
  parameter logic [CODE_W-1:0] TRL_CODE = 8'h9C
) (
  input  logic              is_ctrl,
  input  logic [CODE_W-1:0] low_code,
  output logic              is_trl
);
  always_comb is_trl = is_ctrl && (low_code == TRL_CODE);
endmodule

// File: rtl/flr_ctrl.sv
module flr_ctrl
  import flr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             rx_ready,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             fifo_valid,
  input  logic             fifo_empty,
  input  logic             word_is_trl,
  output logic             fifo_rd_en,
  output logic             accept,
  output logic             cnt_dec,
  output flr_state_e       state
);

  flr_state_e state_nx;
  logic       start_ok;
  logic       last_pop;

  always_comb begin
    start_ok   = (pend_cnt != '0) && rx_ready;
    fifo_rd_en = (state == ST_STREAM) && !fifo_empty && !sw_rst;
    accept     = fifo_rd_en && fifo_valid;
    last_pop   = accept && word_is_trl;
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (start_ok) state_nx = ST_STREAM;
      ST_STREAM: if (last_pop) state_nx = ST_DONE;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
    if (sw_rst) state_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt_dec <= 1'b0;
    end else begin
      state   <= state_nx;
      cnt_dec <= last_pop && !sw_rst;
    end
  end

  // R3: a zero count keeps the controller idle
  a_r3_no_start_on_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && pend_cnt == '0) |=> (state != ST_STREAM));

  // R4: a low ready keeps the controller idle
  a_r4_no_start_unready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !rx_ready) |=> (state != ST_STREAM));

  // R5: a started frame is not abandoned before its trailer
  a_r5_no_abandon: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STREAM && !sw_rst && !(accept && word_is_trl)) |=> (state == ST_STREAM));

  // R6: the decrement request lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cnt_dec |=> !cnt_dec);

  // R7: software reset lands in idle
  a_r7_swrst_idle: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (state == ST_IDLE && !cnt_dec));

  // R8: never read an empty FIFO
  a_r8_empty_guard: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !fifo_rd_en);

  // R11: completion passes through idle
  a_r11_done_to_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE));

endmodule

// File: rtl/flr_tx_stage.sv
module flr_tx_stage #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] IDLE_WORD = 32'h0000_00BC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              accept,
  input  logic [DATA_W:0]   word_in,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_is_k,
  output logic              tx_valid
);

  localparam int FLAG_BIT = DATA_W;

  always_ff @(posedge clk) begin
    if (rst || sw_rst || !accept) begin
      tx_word  <= IDLE_WORD;
      tx_is_k  <= 1'b1;
      tx_valid <= 1'b0;
    end else begin
      tx_word  <= word_in[DATA_W-1:0];
      tx_is_k  <= word_in[FLAG_BIT];
      tx_valid <= 1'b1;
    end
  end

  // R10: an idle cycle carries the idle control word
  a_r10_idle_word: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> (tx_is_k && tx_word == IDLE_WORD));

endmodule

// File: rtl/frame_link_reader.sv
module frame_link_reader
  import flr_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 12,
  parameter int                CODE_W    = 8,
  parameter logic [CODE_W-1:0] TRL_CODE  = 8'h9C,
  parameter logic [DATA_W-1:0] IDLE_WORD = 32'h0000_00BC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              rx_ready,
  input  logic [CNT_W-1:0]  pend_cnt,
  input  logic [DATA_W:0]   fifo_data,
  input  logic              fifo_valid,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  output logic              cnt_dec,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_is_k,
  output logic              tx_valid,
  output logic [MON_W-1:0]  state_mon
);

  localparam int FLAG_BIT = DATA_W;

  flr_state_e state;
  logic       word_is_trl;
  logic       accept;

  flr_trailer_det #(.CODE_W(CODE_W), .TRL_CODE(TRL_CODE)) u_det (
    .is_ctrl  (fifo_data[FLAG_BIT]),
    .low_code (fifo_data[CODE_W-1:0]),
    .is_trl   (word_is_trl)
  );

  flr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sw_rst      (sw_rst),
    .rx_ready    (rx_ready),
    .pend_cnt    (pend_cnt),
    .fifo_valid  (fifo_valid),
    .fifo_empty  (fifo_empty),
    .word_is_trl (word_is_trl),
    .fifo_rd_en  (fifo_rd_en),
    .accept      (accept),
    .cnt_dec     (cnt_dec),
    .state       (state)
  );

  flr_tx_stage #(.DATA_W(DATA_W), .IDLE_WORD(IDLE_WORD)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .sw_rst   (sw_rst),
    .accept   (accept),
    .word_in  (fifo_data),
    .tx_word  (tx_word),
    .tx_is_k  (tx_is_k),
    .tx_valid (tx_valid)
  );

  always_comb state_mon = mon_code(state);

  // R2: a removed word appears on the transmit side one cycle later
  a_r2_word_forwarded: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd_en && fifo_valid) |=>
      (tx_valid && tx_word == $past(fifo_data[DATA_W-1:0]) && tx_is_k == $past(fifo_data[FLAG_BIT])));

  // R6: the decrement request sits beside the trailer word
  a_r6_dec_with_trailer: assert property (@(posedge clk) disable iff (rst)
    cnt_dec |-> (tx_valid && tx_is_k && tx_word[CODE_W-1:0] == TRL_CODE));

  // R9: monitor reads the done code while the decrement is requested
  a_r9_done_code: assert property (@(posedge clk) disable iff (rst)
    cnt_dec |-> (state_mon == 8'h04));

endmodule

// File: tb/sim_frame_link_reader.sv
`timescale 1ns/1ps
module sim_frame_link_reader;

  localparam int  HALF = 4;
  localparam logic [7:0]  HDR_CODE = 8'h3C;
  localparam logic [7:0]  TRL_CODE = 8'h9C;
  localparam logic [31:0] IDLE_W   = 32'h0000_00BC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rst = 1'b0;
  logic        rx_ready = 1'b0;
  logic [11:0] pend_cnt;
  logic [32:0] fifo_data;
  logic        fifo_valid, fifo_empty, fifo_rd_en, cnt_dec;
  logic [31:0] tx_word;
  logic        tx_is_k, tx_valid;
  logic [7:0]  state_mon;

  logic [32:0] mem [0:255];
  logic [7:0]  wr = 8'd0;
  logic [7:0]  rd;
  logic        cnt_inc = 1'b0;

  int checks = 0;
  int errors = 0;
  int dec_seen = 0;
  int inc_sent = 0;

  always #HALF clk = ~clk;

  frame_link_reader u0 (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .rx_ready(rx_ready), .pend_cnt(pend_cnt),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_empty(fifo_empty),
    .fifo_rd_en(fifo_rd_en), .cnt_dec(cnt_dec), .tx_word(tx_word), .tx_is_k(tx_is_k),
    .tx_valid(tx_valid), .state_mon(state_mon)
  );

  // first-word-fall-through FIFO model and frame count register
  assign fifo_empty = (wr == rd);
  assign fifo_valid = !fifo_empty;
  assign fifo_data  = mem[rd];

  always @(posedge clk) begin
    if (rst) begin
      rd <= 8'd0;
      pend_cnt <= 12'd0;
    end else if (sw_rst) begin
      rd <= wr;
      pend_cnt <= 12'd0;
    end else begin
      if (fifo_rd_en && !fifo_empty) rd <= rd + 8'd1;
      pend_cnt <= pend_cnt + {11'd0, cnt_inc} - {11'd0, cnt_dec};
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [32:0] hdr_word();
    hdr_word = {1'b1, 24'($urandom), HDR_CODE};
  endfunction

  function automatic logic [32:0] trl_word();
    trl_word = {1'b1, 24'($urandom), TRL_CODE};
  endfunction

  function automatic logic [32:0] obj_word();
    logic [32:0] w;
    w = {($urandom % 8) == 0, 32'($urandom)};
    if (w[32] && (w[7:0] == TRL_CODE || w[7:0] == HDR_CODE)) w[7:0] = 8'h5A;
    obj_word = w;
  endfunction

  function automatic bit is_hdr(input logic [32:0] w);
    is_hdr = w[32] && w[7:0] == HDR_CODE;
  endfunction

  function automatic bit is_trl(input logic [32:0] w);
    is_trl = w[32] && w[7:0] == TRL_CODE;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic push(input logic [32:0] w);
    mem[wr] = w;
    wr = wr + 8'd1;
  endtask

  task automatic push_frame(input int nobj);
    push(hdr_word());
    for (int i = 0; i < nobj; i++) push(obj_word());
    push(trl_word());
  endtask

  task automatic count_frame();
    cnt_inc = 1'b1;
    inc_sent++;
    tick(1);
    cnt_inc = 1'b0;
  endtask

  task automatic wait_dec(input string req, input int limit);
    int start;
    start = dec_seen;
    for (int i = 0; i < limit && dec_seen == start; i++) tick(1);
    check(dec_seen == start + 1, req, 64'(dec_seen - start), 64'd1);
  endtask

  // scoreboard sampled away from the active edge
  logic [7:0] chk = 8'd0;
  bit   in_frame = 0;
  logic [7:0] prev_mon = 8'h01;
  bit   prev_ready = 0, prev_dec = 0;
  logic [11:0] prev_pend = 12'd0;

  always @(negedge clk) begin
    if (!rst) begin
      if (state_mon == 8'h02 && prev_mon == 8'h01) begin
        check(prev_pend != 12'd0, "R3", 64'(prev_pend), 64'd1);
        check(prev_ready, "R4", 64'(prev_ready), 64'd1);
      end
      if (prev_mon == 8'h04)
        check(state_mon == 8'h01, "R11", 64'(state_mon), 64'h01);
      if (fifo_rd_en && (fifo_empty || state_mon == 8'h01)) begin
        check(0, "R8", 64'(fifo_rd_en), 64'd0);
      end
      if (tx_valid) begin
        check({tx_is_k, tx_word} == mem[chk], "R2", 64'({tx_is_k, tx_word}), 64'(mem[chk]));
        if (!in_frame)
          check(is_hdr({tx_is_k, tx_word}), "R5", 64'({tx_is_k, tx_word}), 64'(mem[chk]));
        in_frame = !is_trl({tx_is_k, tx_word});
        chk = chk + 8'd1;
      end else begin
        if (tx_word != IDLE_W || !tx_is_k)
          check(0, "R10", 64'({tx_is_k, tx_word}), 64'({1'b1, IDLE_W}));
      end
      if (cnt_dec) begin
        dec_seen++;
        check(tx_valid && is_trl({tx_is_k, tx_word}), "R6", 64'({tx_is_k, tx_word}), 64'(TRL_CODE));
        check(!prev_dec, "R6", 64'(prev_dec), 64'd0);
        check(state_mon == 8'h04, "R9", 64'(state_mon), 64'h04);
      end
      if (sw_rst) begin
        chk = wr;
        in_frame = 0;
      end
    end
    prev_mon   = state_mon;
    prev_ready = rx_ready;
    prev_pend  = pend_cnt;
    prev_dec   = cnt_dec;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(100000 * 2 * HALF);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    tick(4);
    @(negedge clk);
    check(state_mon == 8'h01 && !fifo_rd_en && !cnt_dec, "R1", 64'(state_mon), 64'h01);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(!tx_valid && tx_is_k && tx_word == IDLE_W, "R1", 64'({tx_valid, tx_is_k, tx_word}), 64'({2'b01, IDLE_W}));
    check(state_mon == 8'h01, "R1", 64'(state_mon), 64'h01);

    // R3: words present, ready high, count zero
    @(posedge clk); #1;
    rx_ready = 1'b1;
    push(hdr_word()); push(obj_word()); push(obj_word());
    tick(10);
    @(negedge clk);
    check(state_mon == 8'h01 && rd == 8'd0, "R3", 64'(rd), 64'd0);
    @(posedge clk); #1;
    push(obj_word()); push(trl_word());

    // R4: count nonzero, ready low
    rx_ready = 1'b0;
    count_frame();
    tick(10);
    @(negedge clk);
    check(state_mon == 8'h01 && rd == 8'd0, "R4", 64'(rd), 64'd0);
    @(posedge clk); #1;
    rx_ready = 1'b1;
    tick(1);
    @(negedge clk);
    check(state_mon == 8'h02, "R9", 64'(state_mon), 64'h02);
    @(posedge clk); #1;
    wait_dec("R6", 40);
    tick(2);
    check(pend_cnt == 12'd0 && chk == wr, "R2", 64'(chk), 64'(wr));

    // R5: ready drops mid-frame
    push_frame(6);
    count_frame();
    for (int i = 0; i < 20 && state_mon != 8'h02; i++) tick(1);
    tick(2);
    rx_ready = 1'b0;
    wait_dec("R5", 40);
    tick(2);
    check(rd == wr && state_mon == 8'h01, "R5", 64'(rd), 64'(wr));

    // R8 and R10: empty FIFO inside a frame
    push(hdr_word()); push(obj_word());
    rx_ready = 1'b1;
    count_frame();
    tick(8);
    @(negedge clk);
    check(state_mon == 8'h02 && !fifo_rd_en, "R8", 64'(state_mon), 64'h02);
    check(!tx_valid && tx_is_k && tx_word == IDLE_W, "R10", 64'(tx_word), 64'(IDLE_W));
    @(posedge clk); #1;
    push(obj_word()); push(obj_word()); push(trl_word());
    wait_dec("R5", 40);
    tick(2);

    // R7: software reset mid-frame
    push_frame(8);
    count_frame();
    for (int i = 0; i < 20 && state_mon != 8'h02; i++) tick(1);
    tick(3);
    sw_rst = 1'b1;
    @(negedge clk);
    check(!fifo_rd_en, "R7", 64'(fifo_rd_en), 64'd0);
    @(posedge clk); #1;
    sw_rst = 1'b0;
    @(negedge clk);
    check(state_mon == 8'h01 && !tx_valid && !cnt_dec, "R7", 64'(state_mon), 64'h01);
    tick(3);
    check(state_mon == 8'h01 && rd == wr, "R7", 64'(state_mon), 64'h01);

    // random traffic with a toggling ready
    begin
      int d0, i0;
      d0 = dec_seen;
      i0 = inc_sent;
      for (int f = 0; f < 30; f++) begin
        push_frame(int'($urandom % 6));
        count_frame();
        for (int c = 0; c < int'($urandom % 12); c++) begin
          rx_ready = ($urandom % 10) < 7;
          tick(1);
        end
      end
      rx_ready = 1'b1;
      for (int i = 0; i < 2000 && !(pend_cnt == 12'd0 && state_mon == 8'h01); i++) tick(1);
      tick(2);
      check(dec_seen - d0 == inc_sent - i0, "R6", 64'(dec_seen - d0), 64'(inc_sent - i0));
      check(chk == wr && rd == wr, "R5", 64'(chk), 64'(wr));
    end

    // corner: empty frame (header and trailer only), back to back
    push_frame(0); push_frame(0);
    count_frame(); count_frame();
    wait_dec("R5", 40);
    wait_dec("R11", 40);
    tick(3);
    @(negedge clk);
    check(!tx_valid && tx_word == IDLE_W && state_mon == 8'h01, "R10", 64'(tx_word), 64'(IDLE_W));
    check(pend_cnt == 12'd0 && chk == wr, "R2", 64'(chk), 64'(wr));
    finish_run();
  end

endmodule